// File: doc/BRIEF.md
# Serial Two-Wire Memory Slave Protocol Engine

This block is the bus-facing half of a byte-addressed serial memory. It oversamples the two-wire bus clock and data lines with the system clock and recognises start, repeated start and stop conditions. It checks the first byte of each transfer against a fixed device code and three chip-select pins. The block acknowledges by enabling an open-drain pull-down on the data line.

On a write it collects a two-byte word address, high byte first, into an internal pointer. It hands each following data byte to a separate page write engine as a one-cycle strobe that carries the address and the data. A stop commits the collected bytes with a stop strobe. A start that arrives before the stop discards them with a discard strobe. While the write engine reports busy, the block does not acknowledge any control byte, so a master can poll until the write cycle completes.

On a read it presents its pointer to a memory read port that has one cycle of latency. It shifts the returned byte out most significant bit first and keeps sending bytes for as long as the master acknowledges. After each byte the pointer advances by one and wraps across the whole array. The system clock must run at least eight times faster than the bus clock.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is low, no write strobe is pulsed and `rd_addr` is zero.
- R2: A data fall while the clock is high (start) restarts control-byte reception from any state, including the middle of a byte. A data rise while the clock is high (stop) returns the block to idle.
- R3: The control byte is received most significant bit first. Bits 7:4 must equal 4'b1010 and bits 3:1 must equal `cs_pins[2:0]`. Bit 0 selects read (1) or write (0). On any mismatch the block gives no acknowledge and ignores the bus until the next start.
- R4: An acknowledge holds `sda_oe` high through the whole high time of the ninth clock. `sda_oe` never changes while the bus clock is high, except when a start or stop is seen.
- R5: While `wr_busy` is high, a control byte that otherwise matches gets no acknowledge. Once `wr_busy` is low, the same control byte is acknowledged.
- R6: In a write, the byte after the control byte supplies pointer bits 14:8, and its bit 7 is ignored. The next byte supplies bits 7:0. Each further byte pulses `wr_byte` for one cycle with `wr_addr` equal to the pointer and `wr_data` equal to the byte, and the pointer then advances by one.
- R7: A stop after at least one data byte pulses `wr_stop` once. A start before that stop pulses `wr_discard` instead, and the written bytes never reach memory. At most one of the three strobes is high in any cycle.
- R8: A random read consists of a write control byte, two address bytes, a repeated start and a read control byte. It returns the byte at the new address and produces no `wr_byte`, `wr_stop` or `wr_discard`.
- R9: A read that starts without an address phase returns the byte at the address that follows the last byte read or written.
- R10: After a read byte, a master acknowledge makes the block send the next byte. A master no-acknowledge leaves `sda_oe` low until the next start.
- R11: The pointer advances by one after each byte sent or written and wraps from 0x7FFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| cs_pins | input | 3 | Chip-select straps compared with control-byte bits 3:1 |
| sda_oe | output | 1 | Pull-down enable for the open-drain data line |
| wr_byte | output | 1 | One-cycle strobe: a received data byte for the write engine |
| wr_addr | output | ADDR_W | Array address of the strobed data byte |
| wr_data | output | 8 | Strobed data byte |
| wr_stop | output | 1 | One-cycle strobe: commit the collected bytes |
| wr_discard | output | 1 | One-cycle strobe: drop the collected bytes |
| wr_busy | input | 1 | Write engine is running its internal cycle |
| rd_addr | output | ADDR_W | Read port address (the word pointer) |
| rd_data | input | 8 | Read port data, valid one cycle after `rd_addr` |

## Verification
The bench builds the block with its default parameters: a 15-bit pointer and two synchroniser stages. The bus runs at one twenty-fourth of the system clock, so every bus edge reaches the engine well inside a quarter bit. With the full 15-bit pointer, a single address load reaches the 0x7FFF to 0x0000 wrap. A behavioural master and write engine stand around the block. A per-clock comparison of `sda_oe` against the expected bus level during every clock-high window covers acknowledge timing, busy polling and bit order together.

// File: rtl/i2c_mem_slv_pkg.sv
package i2c_mem_slv_pkg;
  // which byte of the transfer is being handled
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT
  } stage_t;
  // where inside a nine-clock byte slot the engine is
  typedef enum logic [1:0] {
    PH_RX, PH_ACK, PH_TX, PH_MACK
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_s;

  // lines reset to the idle (high) level so no false condition is seen
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_word_ptr.sv
module i2c_word_ptr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  // plain binary increment: wraps across the whole array
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + ADDR_W'(1);
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_slv_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        cs_pins,
  output logic              sda_oe,
  output logic              wr_byte,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_stop,
  output logic              wr_discard,
  input  logic              wr_busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int HI_W = ADDR_W - 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  stage_t stage;
  phase_t phase;
  logic [3:0]      cnt;
  logic [7:0]      rx_sh, tx_sh;
  logic            rw_q, pend_q, m_ack;
  logic [HI_W-1:0] hi_q;
  logic            busy_evt, byte_end, ctrl_ok, ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // a regular bus event may act only when no start/stop takes priority
  assign busy_evt = ~start_det & ~stop_det & (stage != ST_IDLE);
  assign byte_end = busy_evt & (phase == PH_RX) & scl_fall & (cnt == 4'd8);
  assign ctrl_ok  = (rx_sh[7:4] == DEV_CODE) & (rx_sh[3:1] == cs_pins) & ~wr_busy;
  assign ptr_load = byte_end & (stage == ST_ALO);
  assign ptr_val  = {hi_q, rx_sh};
  assign ptr_inc  = (byte_end & (stage == ST_WDAT)) |
                    (busy_evt & (phase == PH_TX) & scl_fall & (cnt == 4'd8));

  i2c_word_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .inc(ptr_inc), .ptr(rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage      <= ST_IDLE;
      phase      <= PH_RX;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      rw_q       <= 1'b0;
      pend_q     <= 1'b0;
      m_ack      <= 1'b0;
      hi_q       <= '0;
      sda_oe     <= 1'b0;
      wr_byte    <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_stop    <= 1'b0;
      wr_discard <= 1'b0;
    end else begin
      wr_byte    <= 1'b0;
      wr_stop    <= 1'b0;
      wr_discard <= 1'b0;
      if (start_det) begin
        stage  <= ST_CTRL;
        phase  <= PH_RX;
        cnt    <= '0;
        sda_oe <= 1'b0;
        if (pend_q) wr_discard <= 1'b1;
        pend_q <= 1'b0;
      end else if (stop_det) begin
        stage  <= ST_IDLE;
        sda_oe <= 1'b0;
        if (pend_q) wr_stop <= 1'b1;
        pend_q <= 1'b0;
      end else if (stage != ST_IDLE) begin
        case (phase)
          PH_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              rx_sh <= {rx_sh[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (stage == ST_CTRL) begin
                if (ctrl_ok) begin
                  sda_oe <= 1'b1;
                  phase  <= PH_ACK;
                  rw_q   <= rx_sh[0];
                end else begin
                  stage <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                phase  <= PH_ACK;
                if (stage == ST_AHI) hi_q <= rx_sh[HI_W-1:0];
                if (stage == ST_WDAT) begin
                  wr_byte <= 1'b1;
                  wr_addr <= rd_addr;
                  wr_data <= rx_sh;
                  pend_q  <= 1'b1;
                end
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (stage == ST_CTRL && rw_q) begin
                stage  <= ST_RDAT;
                phase  <= PH_TX;
                sda_oe <= ~rd_data[7];
                tx_sh  <= {rd_data[6:0], 1'b0};
                cnt    <= 4'd1;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
                cnt    <= '0;
                case (stage)
                  ST_CTRL: stage <= ST_AHI;
                  ST_AHI:  stage <= ST_ALO;
                  default: stage <= ST_WDAT;
                endcase
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                phase  <= PH_MACK;
              end else begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                phase  <= PH_TX;
                sda_oe <= ~rd_data[7];
                tx_sh  <= {rd_data[6:0], 1'b0};
                cnt    <= 4'd1;
              end else begin
                stage <= ST_IDLE;
              end
            end
          end
          default: phase <= PH_RX;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_byte,
  input logic              wr_stop,
  input logic              wr_discard,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              ptr_load
);
  // R1: reset leaves the outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_oe && !wr_byte && !wr_stop && !wr_discard && rd_addr == '0));

  // R4: the data drive moves only while the bus clock is low
  a_r4_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_i);

  // R7: commit, discard and byte strobes never overlap
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_byte, wr_stop, wr_discard}));

  // R6: each data byte gives a single-cycle strobe
  a_r6_byte_single: assert property (@(posedge clk) disable iff (rst)
    wr_byte |=> !wr_byte);

  // R11: outside an address load the pointer only steps by one, with wrap
  a_r11_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != $past(rd_addr) && !$past(ptr_load))
      |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .wr_byte(wr_byte),
  .wr_stop(wr_stop), .wr_discard(wr_discard), .rd_addr(rd_addr),
  .ptr_load(ptr_load)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int AW   = 15;
  localparam int MASK = (1 << AW) - 1;
  localparam int Q    = 6;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] cs = 3'b101;
  logic sda_oe, wr_byte, wr_stop, wr_discard, wr_busy;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic bus_sda;
  assign bus_sda = m_sda & ~sda_oe;

  i2c_mem_slave i_i2c_mem_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .cs_pins(cs),
    .sda_oe(sda_oe), .wr_byte(wr_byte), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_stop(wr_stop), .wr_discard(wr_discard), .wr_busy(wr_busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural memory and write engine
  logic [7:0] mem [int];
  int pend_a[$];
  logic [7:0] pend_d[$];
  int busy_cnt = 0, wb_cnt = 0, stop_cnt = 0, disc_cnt = 0;
  int last_a = -1;
  logic [7:0] last_d = 8'h00;
  int mptr = 0;

  function automatic logic [7:0] rd_model(input int a);
    logic [7:0] d;
    if (mem.exists(a)) d = mem[a];
    else d = a[7:0] ^ 8'h5A;
    return d;
  endfunction

  assign wr_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    rd_data <= rd_model(int'(rd_addr));
    if (rst) begin
      busy_cnt = 0;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      if (wr_byte) begin
        pend_a.push_back(int'(wr_addr));
        pend_d.push_back(wr_data);
        wb_cnt++;
        last_a = int'(wr_addr);
        last_d = wr_data;
      end
      if (wr_stop) begin
        foreach (pend_a[i]) mem[pend_a[i]] = pend_d[i];
        pend_a.delete();
        pend_d.delete();
        busy_cnt = BUSY;
        stop_cnt++;
      end
      if (wr_discard) begin
        pend_a.delete();
        pend_d.delete();
        disc_cnt++;
      end
    end
  end

  // per-clock comparison of the data drive against the expected bus level
  bit    exp_valid = 0;
  logic  exp_oe = 1'b0;
  string exp_tag = "R4";
  always @(negedge clk)
    if (exp_valid && !rst)
      chk(sda_oe === exp_oe, exp_tag, "sda_oe while SCL high", sda_oe, exp_oe);

  task automatic wait_q();
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic clk_bit(input logic b, input logic e, input string tag,
                         output logic r);
    m_sda = b; wait_q();
    m_scl = 1'b1;
    repeat (2) @(posedge clk);
    exp_tag = tag; exp_oe = e; exp_valid = 1;
    repeat (Q - 2) @(posedge clk);
    r = bus_sda;
    wait_q();
    exp_valid = 0;
    m_scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack,
                           input string tag);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], 1'b0, "R4", r);
    clk_bit(1'b1, exp_ack, tag, r);
    chk(~r == exp_ack, tag, "acknowledge", ~r, exp_ack);
  endtask

  task automatic recv_byte(input logic mack, input string tag,
                           input logic [7:0] lit);
    logic r;
    logic [7:0] v, e;
    e = rd_model(mptr);
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, ~e[i], tag, r);
      v[i] = r;
    end
    clk_bit(~mack, 1'b0, tag, r);
    mptr = (mptr + 1) & MASK;
    chk(v == lit, tag, "read byte", v, lit);
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] c, input logic rw);
    return {4'b1010, c, rw};
  endfunction

  task automatic addr_write(input int a);
    bus_start();
    send_byte(ctrl(cs, 1'b0), 1'b1, "R3");
    send_byte(8'((a >> 8) & 8'h7F), 1'b1, "R6");
    send_byte(8'(a & 8'hFF), 1'b1, "R6");
    mptr = a & MASK;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    chk(rd_addr == '0, "R1", "rd_addr after reset", rd_addr, 0);
    chk(wb_cnt == 0 && stop_cnt == 0, "R1", "no strobes", wb_cnt + stop_cnt, 0);

    // R6 write with bit 7 of high byte set (ignored), three data bytes
    bus_start();
    send_byte(ctrl(cs, 1'b0), 1'b1, "R3");
    send_byte(8'h80, 1'b1, "R6");
    send_byte(8'h10, 1'b1, "R6");
    mptr = 16'h0010;
    send_byte(8'hA1, 1'b1, "R6");
    chk(last_a == 16'h0010 && last_d == 8'hA1, "R6", "byte 0 addr", last_a, 16'h0010);
    send_byte(8'hB2, 1'b1, "R6");
    chk(last_a == 16'h0011 && last_d == 8'hB2, "R6", "byte 1 addr", last_a, 16'h0011);
    send_byte(8'hC3, 1'b1, "R6");
    chk(last_a == 16'h0012 && last_d == 8'hC3, "R6", "byte 2 addr", last_a, 16'h0012);
    mptr = 16'h0013;
    bus_stop();
    chk(stop_cnt == 1, "R7", "commit strobe count", stop_cnt, 1);
    chk(wb_cnt == 3, "R6", "data strobe count", wb_cnt, 3);

    // R5 polling while busy, then after busy clears
    chk(wr_busy == 1'b1, "R5", "engine busy", wr_busy, 1);
    bus_start();
    send_byte(ctrl(cs, 1'b0), 1'b0, "R5");
    bus_stop();
    wait (busy_cnt == 0);
    repeat (5) @(posedge clk);
    bus_start();
    send_byte(ctrl(cs, 1'b0), 1'b1, "R5");
    bus_stop();
    chk(stop_cnt == 1, "R7", "no commit without data", stop_cnt, 1);

    // R3 chip-select and device-code mismatch
    bus_start();
    send_byte(ctrl(3'b001, 1'b0), 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte({4'b1011, cs, 1'b0}, 1'b0, "R3");
    bus_stop();

    // R8 random read with sequential continuation (R10)
    addr_write(16'h0010);
    bus_start();
    send_byte(ctrl(cs, 1'b1), 1'b1, "R8");
    recv_byte(1'b1, "R8", 8'hA1);
    recv_byte(1'b1, "R10", 8'hB2);
    recv_byte(1'b0, "R10", 8'hC3);
    bus_stop();
    chk(wb_cnt == 3 && disc_cnt == 0 && stop_cnt == 1, "R8", "no write strobes",
        wb_cnt, 3);

    // R9 current-address read, then R10 release after no-acknowledge
    bus_start();
    send_byte(ctrl(cs, 1'b1), 1'b1, "R9");
    recv_byte(1'b0, "R9", 8'h13 ^ 8'h5A);
    begin
      logic r;
      for (int i = 0; i < 3; i++) begin
        clk_bit(1'b1, 1'b0, "R10", r);
        chk(r == 1'b1, "R10", "line released after nack", r, 1);
      end
    end
    bus_stop();

    // R11 pointer wrap at the top of the array
    addr_write(16'h7FFF);
    bus_start();
    send_byte(ctrl(cs, 1'b1), 1'b1, "R11");
    recv_byte(1'b1, "R11", 8'hFF ^ 8'h5A);
    recv_byte(1'b0, "R11", 8'h00 ^ 8'h5A);
    bus_stop();
    chk(rd_addr == 15'd1, "R11", "pointer after wrap", rd_addr, 1);

    // R7 write cut short by a repeated start is discarded
    addr_write(16'h0100);
    send_byte(8'h77, 1'b1, "R7");
    bus_start();
    chk(disc_cnt == 1, "R7", "discard strobe", disc_cnt, 1);
    send_byte(ctrl(cs, 1'b0), 1'b1, "R7");
    bus_stop();
    chk(stop_cnt == 1, "R7", "no commit after discard", stop_cnt, 1);
    addr_write(16'h0100);
    bus_start();
    send_byte(ctrl(cs, 1'b1), 1'b1, "R7");
    recv_byte(1'b0, "R7", 8'h00 ^ 8'h5A);
    bus_stop();

    // R2 start in the middle of a control byte restarts reception
    bus_start();
    begin
      logic r;
      clk_bit(1'b1, 1'b0, "R2", r);
      clk_bit(1'b0, 1'b0, "R2", r);
      clk_bit(1'b1, 1'b0, "R2", r);
      clk_bit(1'b0, 1'b0, "R2", r);
    end
    bus_start();
    send_byte(ctrl(cs, 1'b0), 1'b1, "R2");
    bus_stop();
    @(negedge clk);
    chk(sda_oe == 1'b0, "R2", "idle after stop", sda_oe, 0);

    summary();
  end
endmodule